// File: doc/BRIEF.md
# Interrupt Enable/Flag Controller

This block gathers 32 single-cycle peripheral event pulses into a pending-flag register and turns them into one interrupt request to the processor. It is gated by a 32-bit per-source enable mask and a master enable word. The mask and the flag register are each reached as two 16-bit halves on a small register bus. Software clears a pending flag by writing a 1 to it.

The request is a level that follows the register contents. A write to the mask or to the master enable takes effect at once, as does a flag arriving. A separate wake pulse ends a processor halt when an enabled source fires. The wake pulse ignores the master enable, so a halted processor resumes even with interrupts globally off. Priority and vectoring belong to the processor side.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset every register reads 0 and both `irq_o` and `wake_o` are low.
- R2: Register addresses are: 0 master enable, 1 enable bits 15..0, 2 enable bits 31..16, 3 flag bits 15..0, 4 flag bits 31..16. Source n below 16 maps to bit n of the low half. Source n from 16 up maps to bit n-16 of the high half. Addresses 5 to 7 read 0 and writes to them change nothing.
- R3: A pulse on `event_i[n]` sets flag n at the next clock edge, whatever the enable settings.
- R4: `irq_o` is high exactly when the master enable word is nonzero and enable AND flag is nonzero.
- R5: A write to an enable half while the master enable is nonzero raises `irq_o` in the cycle after the write if the new mask overlaps a pending flag. A write that removes the overlap lowers it.
- R6: A write of a nonzero master enable raises `irq_o` in the cycle after the write if an enabled flag is pending. A write of zero lowers it.
- R7: A write to a flag half clears each bit written as 1 and leaves each bit written as 0 unchanged. `irq_o` falls once no enabled flag remains.
- R8: When an event and a clearing write hit the same flag bit in one cycle, the bit ends up set.
- R9: `wake_o` is high for exactly the one cycle after an edge at which an event arrived on an enabled source. This holds even when the master enable is zero. Events on disabled sources never raise it.
- R10: The master enable and both enable halves read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| event_i | input | 32 | Peripheral event pulses, one per source |
| irq_o | output | 1 | Interrupt request level |
| wake_o | output | 1 | One-cycle wake-from-halt pulse |

## Verification
The assertions watch every cycle for four things. A pulse always lands in its flag. A write of one clears a flag only when no event hits the same bit, and the event wins when both arrive together. The wake pulse follows an enabled event one cycle later. The request stays low whenever the master word is zero. Only the bench's scenarios show the other behaviours. These are the address map and the placement of sources in the two halves, the request being re-evaluated by mask and master writes, readback, and unmapped addresses. The bench sweeps every source in both enabled and disabled settings.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_MASTER  = 3'd0,
    A_EN_LO   = 3'd1,
    A_EN_HI   = 3'd2,
    A_FLAG_LO = 3'd3,
    A_FLAG_HI = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/irq_bus_decode.sv
module irq_bus_decode
  import irq_flag_pkg::*;
#(
  parameter int unsigned NUM_HALF = 2
) (
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic                master_we_o,
  output logic [NUM_HALF-1:0] en_we_o,
  output logic [NUM_HALF-1:0] flag_we_o
);
  always_comb begin
    master_we_o = wr_en_i && (addr_i == A_MASTER);
    en_we_o     = '0;
    flag_we_o   = '0;
    for (int h = 0; h < int'(NUM_HALF); h++) begin
      en_we_o[h]   = wr_en_i && (addr_i == ADDR_W'(int'(A_EN_LO) + h));
      flag_we_o[h] = wr_en_i && (addr_i == ADDR_W'(int'(A_FLAG_LO) + h));
    end
  end
endmodule

// File: rtl/irq_half_bank.sv
module irq_half_bank #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_we_i,
  input  logic         flag_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] en_q_o,
  output logic [W-1:0] flag_q_o
);
  logic [W-1:0] clr_mask;
  logic [W-1:0] flag_d;

  assign clr_mask = flag_we_i ? wdata_i : '0;
  // set has priority over a same-cycle clear
  assign flag_d   = (flag_q_o & ~clr_mask) | evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q_o   <= '0;
      flag_q_o <= '0;
    end else begin
      if (en_we_i) en_q_o <= wdata_i;
      flag_q_o <= flag_d;
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_chk
    p_evt_sets_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[b] |=> flag_q_o[b]);
    p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (evt_i[b] && flag_we_i && wdata_i[b]) |=> flag_q_o[b]);
    p_w1c_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!evt_i[b] && flag_we_i && wdata_i[b]) |=> !flag_q_o[b]);
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [HALF_W-1:0] rdata_o,
  input  logic [NUM_SRC-1:0] event_i,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int unsigned NUM_HALF = NUM_SRC / HALF_W;

  logic                master_we;
  logic [NUM_HALF-1:0] en_we;
  logic [NUM_HALF-1:0] flag_we;
  logic [HALF_W-1:0]   master_q;
  logic [NUM_SRC-1:0]  en_all;
  logic [NUM_SRC-1:0]  flag_all;
  logic                wake_q;

  irq_bus_decode #(.NUM_HALF(NUM_HALF)) u_dec (
    .wr_en_i     (wr_en_i),
    .addr_i      (addr_i),
    .master_we_o (master_we),
    .en_we_o     (en_we),
    .flag_we_o   (flag_we)
  );

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    irq_half_bank #(.W(HALF_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_we_i   (en_we[h]),
      .flag_we_i (flag_we[h]),
      .wdata_i   (wdata_i),
      .evt_i     (event_i[h*HALF_W +: HALF_W]),
      .en_q_o    (en_all[h*HALF_W +: HALF_W]),
      .flag_q_o  (flag_all[h*HALF_W +: HALF_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= '0;
      wake_q   <= 1'b0;
    end else begin
      if (master_we) master_q <= wdata_i;
      // wake ignores the master enable
      wake_q <= |(event_i & en_all);
    end
  end

  assign irq_o  = (|master_q) && (|(en_all & flag_all));
  assign wake_o = wake_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_MASTER) rdata_o = master_q;
    for (int h = 0; h < int'(NUM_HALF); h++) begin
      if (addr_i == ADDR_W'(int'(A_EN_LO) + h))   rdata_o = en_all[h*HALF_W +: HALF_W];
      if (addr_i == ADDR_W'(int'(A_FLAG_LO) + h)) rdata_o = flag_all[h*HALF_W +: HALF_W];
    end
  end

  p_wake_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(event_i & en_all)) |=> wake_o);
  p_no_wake_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(event_i & en_all)) |=> !wake_o);
  p_irq_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_q == '0) |-> !irq_o);
  p_master_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (master_we && wdata_i == '0) |=> !irq_o);
endmodule

// File: tb/tb_irq_flag_ctrl.sv
module tb_irq_flag_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [31:0] event_v = '0;
  logic        irq, wake;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_flag_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .event_i(event_v),
    .irq_o(irq), .wake_o(wake)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one cycle: optional write plus event pulse, sample after edge
  task automatic cyc(input bit we, input logic [2:0] a, input logic [15:0] d, input logic [31:0] ev);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; event_v = ev;
    @(posedge clk); #1;
    @(negedge clk);
    wr_en = 1'b0; event_v = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wake_after(input logic [31:0] ev, output logic w, output logic i);
    @(negedge clk); event_v = ev;
    @(posedge clk); #1; w = wake; i = irq;
    @(negedge clk); event_v = '0;
  endtask

  initial begin
    logic [15:0] v;
    logic w, i;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 irq", irq, 0); chk("R1 wake", wake, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R1 reset read", v, 0);
    end
    @(negedge clk); rst_ni = 1'b1;

    // R10 readback, R2 unmapped
    cyc(1, 3'd0, 16'h0001, 0); rd(3'd0, v); chk("R10 master", v, 16'h0001);
    cyc(1, 3'd1, 16'hA5C3, 0); rd(3'd1, v); chk("R10 en_lo", v, 16'hA5C3);
    cyc(1, 3'd2, 16'h3C5A, 0); rd(3'd2, v); chk("R10 en_hi", v, 16'h3C5A);
    for (int a = 5; a < 8; a++) begin
      cyc(1, 3'(a), 16'hFFFF, 0); rd(3'(a), v); chk("R2 unmapped read", v, 0);
    end
    rd(3'd1, v); chk("R2 unmapped no effect", v, 16'hA5C3);
    chk("R2 unmapped no irq", irq, 0);

    // sweep every source, enabled and disabled
    for (int n = 0; n < 32; n++) begin
      logic [31:0] m;
      int o;
      m = 32'h1 << n;
      o = n ^ 1;
      cyc(1, 3'd1, m[15:0], 0);
      cyc(1, 3'd2, m[31:16], 0);
      wake_after(m, w, i);
      chk($sformatf("R9 wake src %0d", n), w, 1);
      chk($sformatf("R4 irq src %0d", n), i, 1);
      @(posedge clk); #1; chk("R9 wake one cycle", wake, 0);
      rd(n < 16 ? 3'd3 : 3'd4, v);
      chk($sformatf("R2 flag pos src %0d", n), v, 16'h1 << (n % 16));
      rd(n < 16 ? 3'd4 : 3'd3, v); chk("R2 other half", v, 0);
      cyc(1, n < 16 ? 3'd3 : 3'd4, 16'h1 << (n % 16), 0);
      chk("R7 irq drop", irq, 0);
      rd(n < 16 ? 3'd3 : 3'd4, v); chk("R7 cleared", v, 0);
      wake_after(32'h1 << o, w, i);
      chk($sformatf("R9 no wake disabled src %0d", o), w, 0);
      chk("R4 no irq disabled", i, 0);
      rd(o < 16 ? 3'd3 : 3'd4, v);
      chk($sformatf("R3 flag disabled src %0d", o), v, 16'h1 << (o % 16));
      cyc(1, o < 16 ? 3'd3 : 3'd4, 16'hFFFF, 0);
    end

    // master zero: wake but no irq; R6 master write
    cyc(1, 3'd0, 16'h0000, 0);
    cyc(1, 3'd1, 16'h0010, 0);
    cyc(1, 3'd2, 16'h0000, 0);
    wake_after(32'h10, w, i);
    chk("R9 wake with master off", w, 1);
    chk("R4 no irq master off", i, 0);
    cyc(1, 3'd0, 16'h8000, 0); chk("R6 master raises irq", irq, 1);
    cyc(1, 3'd0, 16'h0000, 0); chk("R6 master zero lowers", irq, 0);
    cyc(1, 3'd0, 16'h0002, 0); chk("R6 master nonzero again", irq, 1);

    // R5 enable write re-evaluation
    cyc(1, 3'd1, 16'h0000, 0); chk("R5 mask removed", irq, 0);
    cyc(1, 3'd2, 16'h0040, 0); chk("R5 no overlap", irq, 0);
    cyc(0, 3'd0, 0, 32'h0040_0000); chk("R3 high event", irq, 1);
    cyc(1, 3'd2, 16'h0000, 0); chk("R5 mask hi removed", irq, 0);
    cyc(1, 3'd1, 16'h0010, 0); chk("R5 mask lo restores", irq, 1);

    // R7 write zero keeps, partial clear
    cyc(1, 3'd3, 16'h0000, 0); rd(3'd3, v); chk("R7 write zero keeps", v, 16'h0010);
    cyc(1, 3'd3, 16'h0001, 0); rd(3'd3, v); chk("R7 other bit keeps", v, 16'h0010);
    chk("R7 irq still", irq, 1);
    cyc(1, 3'd4, 16'h0040, 0); rd(3'd4, v); chk("R7 hi clear", v, 0);
    chk("R7 irq kept by lo", irq, 1);

    // R8 set wins over clear
    cyc(1, 3'd3, 16'h0010, 32'h10); rd(3'd3, v); chk("R8 set wins", v, 16'h0010);
    chk("R8 irq stays", irq, 1);
    cyc(1, 3'd3, 16'h0010, 32'h20); rd(3'd3, v); chk("R8 clear one set other", v, 16'h0020);
    chk("R7 irq off after clear", irq, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule